// File: doc/BRIEF.md
# Nonvolatile Wiper Setting Sequencer

This block keeps an 8-bit wiper register in step with a nonvolatile copy of that setting. When reset is released (power-up), the register already reads midscale. The sequencer then reads the stored setting from the nonvolatile memory port and copies it into the register once the restore time has elapsed. After that, a command decoder can request a store, a restore or a no-operation. Each request is a single-cycle pulse and carries no data. Ordinary register writes arrive on a separate write strobe.

Every timing window is counted in clock cycles. The cycle count is the time in microseconds multiplied by `CLK_HZ` and divided by one million, with a floor of 4 cycles. The three windows are:
- restore time: 300 µs
- store (programming) time: 26 ms
- rewrite lockout that follows power-up: 540 µs

No nonvolatile write is issued until the lockout has expired. A store requested earlier is held and launched when the lockout ends. When a commanded restore completes, the block enters a read power state and stays there until a no-operation command arrives while the block is idle. A command that cannot be taken is dropped and recorded in a sticky error flag.

Top module: `nvset_seq`

## Requirements
- R1: While reset is held, `wiper` reads 0x80, `busy` is 1, and `err`, `pwr_read`, `nv_rd` and `nv_wr` are 0.
- R2: After reset is released, `busy` stays high for the restore count plus the boot cycle. `wiper` holds 0x80 until the restore count ends, then takes the memory word at `SET_ADDR`. A blank memory (every word 0x80) therefore gives 0x80. One `nv_rd` pulse is issued.
- R3: A restore pulse accepted while idle gives exactly one one-cycle `nv_rd` and keeps `busy` high for exactly the restore count. `wiper` then becomes the stored word.
- R4: A store pulse accepted while idle (lockout over) gives one one-cycle `nv_wr` at `SET_ADDR`. The data is the wiper value when the store starts. `busy` stays high for exactly the store count.
- R5: No `nv_wr` appears while the rewrite lockout is open. A store requested during the lockout raises `busy` at once. Its `nv_wr` is first visible two cycles after the lockout count ends, measured from the first clock edge after reset release.
- R6: `pwr_read` rises when a commanded restore completes, never after the power-on restore. A no-operation pulse clears it only while idle; one arriving during a busy operation leaves it set.
- R7: A store or restore pulse that arrives while `busy` is high is dropped. It issues no memory strobe, does not stretch the running operation, and sets `err`, which stays 1 until reset.
- R8: Store and restore pulses in the same idle cycle run the restore only. The store is dropped and `err` is set.
- R9: A `wr_en` pulse loads `wr_data` into `wiper` on the next edge. In the cycle where a restore loads the wiper, the restored value wins over `wr_en`.
- R10: A cycle counter expires exactly the programmed number of cycles after it is started and then stays idle until started again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, treated as power-up |
| cmd_store | input | 1 | Pulse: copy wiper into nonvolatile memory |
| cmd_restore | input | 1 | Pulse: copy nonvolatile word into wiper |
| cmd_nop | input | 1 | Pulse: leave the read power state |
| wr_en | input | 1 | Pulse: direct wiper write |
| wr_data | input | DW | Direct write value |
| wiper | output | DW | Current wiper setting |
| busy | output | 1 | Operation or boot sequence in progress |
| pwr_read | output | 1 | Read power state after commanded restore |
| err | output | 1 | Sticky dropped-command flag |
| nv_rd | output | 1 | Memory read strobe (data one cycle later) |
| nv_wr | output | 1 | Memory write strobe |
| nv_addr | output | AW | Memory word address |
| nv_wdata | output | DW | Memory write data |
| nv_rdata | input | DW | Memory read data |

## Verification
On every cycle, the assertions check the following:
- both memory strobes last exactly one cycle;
- a write strobe is seen only while busy and only after the lockout has closed;
- the read power state rises only as busy falls;
- the error flag never drops;
- a restore load always wins over a direct write in the same cycle;
- the counters go quiet after expiry.

The exact lengths of the busy windows, the midscale value seen before the restore lands, the launch cycle of a deferred store, and the memory contents written are shown only by the bench scenarios, which count cycles against a behavioural memory.

// File: rtl/nvset_pkg.sv
package nvset_pkg;

  typedef enum logic [2:0] {
    SQ_BOOT    = 3'd0,
    SQ_RESTORE = 3'd1,
    SQ_SWAIT   = 3'd2,
    SQ_STORE   = 3'd3,
    SQ_IDLE    = 3'd4
  } seq_state_e;

  // Converts a duration in microseconds to clock cycles, never below 4 so
  // that the memory read data is always captured before the load.
  function automatic int unsigned us_to_cyc(input longint unsigned hz,
                                            input longint unsigned us);
    longint unsigned c;
    c = (hz * us) / 64'd1_000_000;
    if (c < 64'd4) c = 64'd4;
    return 32'(c);
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nvset_delay.sv
module nvset_delay #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (start)         cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign done = (cnt == CW'(1));

  // R10: after expiry the counter is idle unless restarted
  p_done_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (cnt == '0));

endmodule

// File: rtl/nvset_wiper.sv
module nvset_wiper #(
  parameter int unsigned   DW  = 8,
  parameter logic [DW-1:0] MID = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [DW-1:0] ld_val,
  input  logic          wr,
  input  logic [DW-1:0] wr_val,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= MID;
    else if (ld)  q <= ld_val;
    else if (wr)  q <= wr_val;
  end

  // R9: restore load has priority over a same-cycle direct write
  p_load_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (q == $past(ld_val)));

  // R9: no strobe, no change
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !wr) |=> $stable(q));

endmodule

// File: rtl/nvset_ctrl.sv
module nvset_ctrl
  import nvset_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned CW      = 16,
  parameter int unsigned RST_CYC = 30,
  parameter int unsigned STO_CYC = 2600
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_store,
  input  logic          cmd_restore,
  input  logic          cmd_nop,
  input  logic          op_done,
  input  logic          win_done,
  input  logic [DW-1:0] nv_rdata,
  input  logic [DW-1:0] wiper_q,
  output logic          op_start,
  output logic [CW-1:0] op_len,
  output logic          win_start,
  output logic          ld,
  output logic [DW-1:0] ld_val,
  output logic          nv_rd,
  output logic          nv_wr,
  output logic [DW-1:0] nv_wdata,
  output logic          busy,
  output logic          pwr_read,
  output logic          err
);

  seq_state_e    state;
  logic          rd_pend;
  logic [DW-1:0] rd_buf;
  logic          from_cmd;
  logic          win_ok;

  // named internal events
  logic accept_rs, accept_st, st_launch, drop_cmd;

  assign accept_rs = (state == SQ_IDLE) && cmd_restore;
  assign accept_st = (state == SQ_IDLE) && cmd_store && !cmd_restore;
  assign st_launch = (accept_st && win_ok) || ((state == SQ_SWAIT) && win_ok);
  assign drop_cmd  = ((state != SQ_IDLE) && (cmd_store || cmd_restore)) ||
                     ((state == SQ_IDLE) && cmd_store && cmd_restore);

  assign op_start  = (state == SQ_BOOT) || accept_rs || st_launch;
  assign op_len    = st_launch ? CW'(STO_CYC) : CW'(RST_CYC);
  assign win_start = (state == SQ_BOOT);
  assign ld        = (state == SQ_RESTORE) && op_done;
  assign ld_val    = rd_buf;
  assign busy      = (state != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_BOOT;
      nv_rd    <= 1'b0;
      nv_wr    <= 1'b0;
      nv_wdata <= '0;
      rd_pend  <= 1'b0;
      rd_buf   <= '0;
      from_cmd <= 1'b0;
      win_ok   <= 1'b0;
      pwr_read <= 1'b0;
      err      <= 1'b0;
    end else begin
      nv_rd   <= 1'b0;
      nv_wr   <= 1'b0;
      rd_pend <= nv_rd;
      if (rd_pend)  rd_buf <= nv_rdata;
      if (win_done) win_ok <= 1'b1;
      if (drop_cmd) err    <= 1'b1;
      case (state)
        SQ_BOOT: begin
          nv_rd    <= 1'b1;
          from_cmd <= 1'b0;
          state    <= SQ_RESTORE;
        end
        SQ_IDLE: begin
          if (accept_rs) begin
            nv_rd    <= 1'b1;
            from_cmd <= 1'b1;
            state    <= SQ_RESTORE;
          end else if (accept_st) begin
            if (win_ok) begin
              nv_wr    <= 1'b1;
              nv_wdata <= wiper_q;
              state    <= SQ_STORE;
            end else begin
              state    <= SQ_SWAIT;
            end
          end else if (cmd_nop) begin
            pwr_read <= 1'b0;
          end
        end
        SQ_RESTORE: begin
          if (op_done) begin
            state <= SQ_IDLE;
            if (from_cmd) pwr_read <= 1'b1;
          end
        end
        SQ_SWAIT: begin
          if (win_ok) begin
            nv_wr    <= 1'b1;
            nv_wdata <= wiper_q;
            state    <= SQ_STORE;
          end
        end
        SQ_STORE: begin
          if (op_done) state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R3: read strobe is a single-cycle pulse
  p_rd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    nv_rd |=> !nv_rd);

  // R4: write strobe is a single-cycle pulse, issued only while busy
  p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr |=> !nv_wr);
  p_wr_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr |-> busy);

  // R5: no memory write before the rewrite lockout closes
  p_nvwr_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr |-> win_ok);

  // R6: read power state can only appear as an operation ends
  p_pwr_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_read) |-> $fell(busy));

  // R7: error flag is sticky
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

// File: rtl/nvset_seq.sv
module nvset_seq
  import nvset_pkg::*;
#(
  parameter int unsigned   DW         = 8,
  parameter int unsigned   AW         = 4,
  parameter logic [AW-1:0] SET_ADDR   = 4'h3,
  parameter int unsigned   CLK_HZ     = 250_000_000,
  parameter int unsigned   RESTORE_US = 300,
  parameter int unsigned   STORE_US   = 26_000,
  parameter int unsigned   REWRITE_US = 540
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_store,
  input  logic          cmd_restore,
  input  logic          cmd_nop,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] wiper,
  output logic          busy,
  output logic          pwr_read,
  output logic          err,
  output logic          nv_rd,
  output logic          nv_wr,
  output logic [AW-1:0] nv_addr,
  output logic [DW-1:0] nv_wdata,
  input  logic [DW-1:0] nv_rdata
);

  localparam int unsigned   RST_CYC = us_to_cyc(CLK_HZ, RESTORE_US);
  localparam int unsigned   STO_CYC = us_to_cyc(CLK_HZ, STORE_US);
  localparam int unsigned   WIN_CYC = us_to_cyc(CLK_HZ, REWRITE_US);
  localparam int unsigned   CW      = $clog2(max_u(RST_CYC, STO_CYC) + 1);
  localparam int unsigned   WW      = $clog2(WIN_CYC + 1);
  localparam logic [DW-1:0] MID     = DW'(1) << (DW - 1);

  logic          op_start, op_done, win_start, win_done, ld;
  logic [CW-1:0] op_len;
  logic [DW-1:0] ld_val;

  assign nv_addr = SET_ADDR;

  nvset_ctrl #(
    .DW(DW), .CW(CW), .RST_CYC(RST_CYC), .STO_CYC(STO_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_store(cmd_store), .cmd_restore(cmd_restore), .cmd_nop(cmd_nop),
    .op_done(op_done), .win_done(win_done),
    .nv_rdata(nv_rdata), .wiper_q(wiper),
    .op_start(op_start), .op_len(op_len), .win_start(win_start),
    .ld(ld), .ld_val(ld_val),
    .nv_rd(nv_rd), .nv_wr(nv_wr), .nv_wdata(nv_wdata),
    .busy(busy), .pwr_read(pwr_read), .err(err)
  );

  nvset_delay #(.CW(CW)) u_op_tmr (
    .clk(clk), .rst_n(rst_n), .start(op_start), .load_val(op_len), .done(op_done)
  );

  nvset_delay #(.CW(WW)) u_win_tmr (
    .clk(clk), .rst_n(rst_n), .start(win_start), .load_val(WW'(WIN_CYC)),
    .done(win_done)
  );

  nvset_wiper #(.DW(DW), .MID(MID)) u_wiper (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_val(ld_val),
    .wr(wr_en), .wr_val(wr_data), .q(wiper)
  );

endmodule

// File: tb/tb_nvset_seq.sv
module tb_nvset_seq;

  localparam int TB_HZ  = 100_000;
  // cycles per microsecond is 0.1 at this clock setting
  localparam int TB_RC  = 300 / 10;
  localparam int TB_SC  = 26_000 / 10;
  localparam int TB_WC  = 540 / 10;
  localparam logic [3:0] ADDR = 4'h3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_store = 1'b0, cmd_restore = 1'b0, cmd_nop = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] wiper, nv_wdata, nv_rdata;
  logic [3:0] nv_addr;
  logic       busy, pwr_read, err, nv_rd, nv_wr;

  logic [7:0] mem [16];
  int rd_cnt = 0, wr_cnt = 0;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  nvset_seq #(.CLK_HZ(TB_HZ)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_store(cmd_store), .cmd_restore(cmd_restore),
    .cmd_nop(cmd_nop), .wr_en(wr_en), .wr_data(wr_data), .wiper(wiper),
    .busy(busy), .pwr_read(pwr_read), .err(err), .nv_rd(nv_rd), .nv_wr(nv_wr),
    .nv_addr(nv_addr), .nv_wdata(nv_wdata), .nv_rdata(nv_rdata)
  );

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'h80;
    nv_rdata = 8'h00;
  end

  always @(posedge clk) begin
    if (nv_wr) mem[nv_addr] <= nv_wdata;
    if (nv_rd) nv_rdata <= mem[nv_addr];
    if (nv_rd) rd_cnt <= rd_cnt + 1;
    if (nv_wr) wr_cnt <= wr_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic issue(input bit st, input bit rs, input bit np);
    cmd_store = st; cmd_restore = rs; cmd_nop = np;
    tick();
    cmd_store = 1'b0; cmd_restore = 1'b0; cmd_nop = 1'b0;
  endtask

  task automatic write_w(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    tick();
    wr_en = 1'b0;
  endtask

  // counts cycles with busy high; snapshots wiper in the last busy cycle
  task automatic count_busy(output int n, output logic [7:0] last_w);
    n = 0; last_w = wiper;
    while (busy && n < 20000) begin
      n++; last_w = wiper;
      tick();
    end
  endtask

  task automatic power_up(output int n, output logic [7:0] last_w);
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    count_busy(n, last_w);
  endtask

  localparam logic [15:0] VEC [4] = '{16'h00FF, 16'hFF01, 16'h5AA5, 16'hC43B};

  initial begin : main
    int n, t, rd0, wr0;
    logic [7:0] lw;
    repeat (3) tick();
    // R1: reset state
    chk(wiper == 8'h80, "R1 wiper", wiper, 8'h80);
    chk(busy == 1'b1, "R1 busy", busy, 1);
    chk(!err && !pwr_read && !nv_rd && !nv_wr, "R1 flags", {err, pwr_read, nv_rd, nv_wr}, 0);

    // R2: blank power-up
    rst_n = 1'b1;
    tick();
    count_busy(n, lw);
    chk(n == TB_RC, "R2 boot busy", n, TB_RC);
    chk(lw == 8'h80, "R2 midscale before load", lw, 8'h80);
    chk(wiper == 8'h80, "R2 blank result", wiper, 8'h80);
    chk(rd_cnt == 1, "R2 one read", rd_cnt, 1);
    chk(pwr_read == 1'b0, "R6 no read state after boot", pwr_read, 0);

    // R5: store inside lockout waits (now at cycle TB_RC+1 after release)
    t = TB_RC + 1;
    write_w(8'h3C); t++;
    chk(wiper == 8'h3C, "R9 direct write", wiper, 8'h3C);
    issue(1'b1, 1'b0, 1'b0); t++;
    chk(busy == 1'b1, "R5 busy while deferred", busy, 1);
    while (!nv_wr && t < 1000) begin tick(); t++; end
    chk(t == TB_WC + 2, "R5 deferred launch cycle", t, TB_WC + 2);
    count_busy(n, lw);
    chk(mem[ADDR] == 8'h3C, "R4 deferred store data", mem[ADDR], 8'h3C);
    chk(wr_cnt == 1, "R4 one write", wr_cnt, 1);

    // table walk: store A, overwrite with B, restore A
    for (int i = 0; i < 4; i++) begin
      logic [7:0] a, b;
      a = VEC[i][15:8]; b = VEC[i][7:0];
      wr0 = wr_cnt; rd0 = rd_cnt;
      write_w(a);
      issue(1'b1, 1'b0, 1'b0);
      count_busy(n, lw);
      chk(n == TB_SC, "R4 store busy", n, TB_SC);
      chk(mem[ADDR] == a, "R4 stored word", mem[ADDR], a);
      chk(wr_cnt == wr0 + 1, "R4 write pulses", wr_cnt, wr0 + 1);
      write_w(b);
      chk(wiper == b, "R9 write", wiper, b);
      issue(1'b0, 1'b1, 1'b0);
      count_busy(n, lw);
      chk(n == TB_RC, "R3 restore busy", n, TB_RC);
      chk(wiper == a, "R3 restored", wiper, a);
      chk(rd_cnt == rd0 + 1, "R3 read pulses", rd_cnt, rd0 + 1);
      chk(pwr_read == 1'b1, "R6 read state set", pwr_read, 1);
      issue(1'b0, 1'b0, 1'b1);
      chk(pwr_read == 1'b0, "R6 nop clears", pwr_read, 0);
    end

    // R6: nop during a busy store leaves read state set
    issue(1'b0, 1'b1, 1'b0);
    count_busy(n, lw);
    issue(1'b1, 1'b0, 1'b0);
    repeat (5) tick();
    issue(1'b0, 1'b0, 1'b1);
    count_busy(n, lw);
    chk(pwr_read == 1'b1, "R6 nop while busy ignored", pwr_read, 1);
    issue(1'b0, 1'b0, 1'b1);
    chk(pwr_read == 1'b0, "R6 idle nop", pwr_read, 0);

    // R9: direct write in the load cycle loses to restore
    write_w(8'h77);
    issue(1'b0, 1'b1, 1'b0);
    repeat (TB_RC - 1) tick();
    wr_en = 1'b1; wr_data = 8'h11;
    tick();
    wr_en = 1'b0;
    chk(wiper == 8'hC4, "R9 restore wins", wiper, 8'hC4);
    chk(busy == 1'b0, "R3 idle after load", busy, 0);

    // R7: store during restore dropped
    wr0 = wr_cnt;
    chk(err == 1'b0, "R7 err clear before", err, 0);
    issue(1'b0, 1'b1, 1'b0);
    repeat (4) tick();
    issue(1'b1, 1'b0, 1'b0);
    count_busy(n, lw);
    chk(n == TB_RC - 5, "R7 restore not stretched", n, TB_RC - 5);
    chk(wr_cnt == wr0, "R7 no write", wr_cnt, wr0);
    chk(err == 1'b1, "R7 err set", err, 1);
    repeat (10) tick();
    chk(err == 1'b1, "R7 err sticky", err, 1);

    // R2 with stored word, R1 err cleared by reset
    mem[ADDR] = 8'hA7;
    power_up(n, lw);
    chk(n == TB_RC, "R2 boot busy", n, TB_RC);
    chk(lw == 8'h80, "R2 preset midscale", lw, 8'h80);
    chk(wiper == 8'hA7, "R2 stored value", wiper, 8'hA7);
    chk(err == 1'b0, "R1 reset clears err", err, 0);

    // R8: simultaneous store and restore
    repeat (TB_WC) tick();
    wr0 = wr_cnt; rd0 = rd_cnt;
    write_w(8'h42);
    issue(1'b1, 1'b1, 1'b0);
    count_busy(n, lw);
    chk(n == TB_RC, "R8 restore ran", n, TB_RC);
    chk(wiper == 8'hA7, "R8 restored", wiper, 8'hA7);
    chk(wr_cnt == wr0 && rd_cnt == rd0 + 1, "R8 strobes", wr_cnt, wr0);
    chk(err == 1'b1, "R8 err", err, 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (200_000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule